// File: doc/BRIEF.md
# Sift-Out Redundant Bus Voter

This block merges one bus word from each of three computers that execute the same program in lock-step from a shared clock. Each clock period the three words are compared. A computer whose word differs from the two others is dropped from the merged output in that same cycle. A latch then holds it out. The merged output is the bitwise OR of the words from every channel that is still connected. Once the system has sifted down to two channels, a disagreement between them cannot be blamed on either one. The block then raises a separate sticky mismatch flag and disconnects nothing.

The processors see the block through a small command port. A read strobe at the status address gates a byte holding the per-channel fault bits and the mismatch bit. A write strobe at the clear address reconnects all channels and clears every flag. Software uses this after it has repaired memory and resynchronised the programs.

Top module: `sift_voter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all three fault flags and the mismatch flag are 0, every channel is connected, and the status read returns 0.
- R2: When all connected channels carry equal words, `bus_out` equals that word in the same cycle.
- R3: When all three channels are connected and exactly one differs from the two equal others, `bus_out` leaves that channel out in the same cycle, so it equals the OR of the two agreeing words.
- R4: The fault flag of a channel that was sifted out rises on the next clock edge. Bit 0 is channel a, bit 1 is channel b and bit 2 is channel c. The flag stays set until a clear command.
- R5: A channel whose fault flag is set does not contribute to `bus_out` and takes no part in later comparisons. Its changes never set another fault flag, so at most one fault flag is set at any time.
- R6: With two channels connected and their words different, `mismatch` rises on the next edge and stays set until cleared. No further channel is disconnected, and `bus_out` is the OR of both words.
- R7: With three channels connected and all three words pairwise different, `mismatch` rises on the next edge and no fault flag is set.
- R8: When `cmd_rd` is high and `cmd_addr` equals `STAT_ADDR`, `rd_data` holds the fault flags in bits 2..0 and the mismatch flag in bit 3, with bits 7..4 zero. In every other cycle `rd_data` is 0.
- R9: When `cmd_wr` is high and `cmd_addr` equals `CLR_ADDR`, all fault flags and the mismatch flag are 0 after the next edge and all channels are reconnected. The clear wins over a detection in the same cycle.
- R10: A write to any address other than `CLR_ADDR`, or a read of `CLR_ADDR`, leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared lock-step clock; comparison edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_a | input | W | Bus word of channel a |
| data_b | input | W | Bus word of channel b |
| data_c | input | W | Bus word of channel c |
| bus_out | output | W | OR of the connected, agreeing channels |
| fault_flags | output | 3 | Latched per-channel disconnect flags |
| mismatch | output | 1 | Sticky unresolvable-disagreement flag |
| cmd_addr | input | AW | Processor address for commands |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| rd_data | output | 8 | Gated status byte |

## Verification
The assertions assume that no more than one channel fails in a cycle while all three are connected. They also assume that the clear strobe is a clean, synchronous pulse. The random stimulus mostly drives all three channels with one shared word. Now and then it flips bits in one connected channel only, and it issues clears and reads at random. Directed sequences cover the cases that break the one-fault assumption on purpose: a three-way disagreement, and disagreement after sifting down to two. In those cases the block must fall back to the mismatch flag rather than latch a second channel out.

// File: rtl/sov_pkg.sv
package sov_pkg;
    localparam int NCH    = 3;
    localparam int STAT_W = 8;

    typedef logic [NCH-1:0] chmask_t;

    typedef struct packed {
        chmask_t fault;
        logic    unres;
    } sov_state_t;
endpackage

// File: rtl/sov_compare.sv
module sov_compare
    import sov_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NCH-1:0][W-1:0] ch,
    input  chmask_t               live,
    output chmask_t               odd,
    output logic                  unres
);
    logic eq01, eq02, eq12;

    always_comb begin
        eq01  = (ch[0] == ch[1]);
        eq02  = (ch[0] == ch[2]);
        eq12  = (ch[1] == ch[2]);
        odd   = '0;
        unres = 1'b0;
        if (live == 3'b111) begin
            if (eq01 && eq02) begin
                odd = '0;
            end else if (eq01) begin
                odd = 3'b100;
            end else if (eq02) begin
                odd = 3'b010;
            end else if (eq12) begin
                odd = 3'b001;
            end else begin
                unres = 1'b1;
            end
        end else begin
            unres = (live == 3'b110 && !eq12) ||
                    (live == 3'b101 && !eq02) ||
                    (live == 3'b011 && !eq01);
        end
    end
endmodule

// File: rtl/sov_collector.sv
module sov_collector
    import sov_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NCH-1:0][W-1:0] ch,
    input  chmask_t               keep,
    output logic [W-1:0]          bus
);
    always_comb begin
        bus = '0;
        for (int i = 0; i < NCH; i++) begin
            if (keep[i]) begin
                bus = bus | ch[i];
            end
        end
    end
endmodule

// File: rtl/sov_cmd.sv
module sov_cmd
    import sov_pkg::*;
#(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   STAT_ADDR = 16'hFF40,
    parameter logic [AW-1:0]   CLR_ADDR  = 16'hFF41
) (
    input  logic [AW-1:0]     addr,
    input  logic              rd,
    input  logic              wr,
    input  sov_state_t        st,
    output logic              clr_hit,
    output logic [STAT_W-1:0] rd_data
);
    localparam int PAD = STAT_W - NCH - 1;

    always_comb begin
        clr_hit = wr && (addr == CLR_ADDR);
        if (rd && (addr == STAT_ADDR)) begin
            rd_data = {{PAD{1'b0}}, st.unres, st.fault};
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/sift_voter.sv
module sift_voter
    import sov_pkg::*;
#(
    parameter int            W         = 8,
    parameter int            AW        = 16,
    parameter logic [AW-1:0] STAT_ADDR = 16'hFF40,
    parameter logic [AW-1:0] CLR_ADDR  = 16'hFF41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      data_a,
    input  logic [W-1:0]      data_b,
    input  logic [W-1:0]      data_c,
    output logic [W-1:0]      bus_out,
    output logic [NCH-1:0]    fault_flags,
    output logic              mismatch,
    input  logic [AW-1:0]     cmd_addr,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    output logic [STAT_W-1:0] rd_data
);
    logic [NCH-1:0][W-1:0] chans;
    sov_state_t            state_d, state_q;
    chmask_t               live, odd, keep;
    logic                  unres, clr_hit;

    assign chans = {data_c, data_b, data_a};
    assign live  = ~state_q.fault;
    assign keep  = live & ~odd;

    sov_compare #(.W(W)) u_cmp (
        .ch    (chans),
        .live  (live),
        .odd   (odd),
        .unres (unres)
    );

    sov_collector #(.W(W)) u_col (
        .ch   (chans),
        .keep (keep),
        .bus  (bus_out)
    );

    sov_cmd #(.AW(AW), .STAT_ADDR(STAT_ADDR), .CLR_ADDR(CLR_ADDR)) u_cmd (
        .addr    (cmd_addr),
        .rd      (cmd_rd),
        .wr      (cmd_wr),
        .st      (state_q),
        .clr_hit (clr_hit),
        .rd_data (rd_data)
    );

    always_comb begin
        state_d = state_q;
        if (clr_hit) begin
            state_d = '0;
        end else begin
            state_d.fault = state_q.fault | odd;
            state_d.unres = state_q.unres | unres;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fault_flags = state_q.fault;
    assign mismatch    = state_q.unres;

    // R5
    single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q.fault) <= 1);

    // R4
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((state_q.fault & $past(state_q.fault)) == $past(state_q.fault)));

    // R3
    drop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (odd != '0) |-> ($countones(odd) == 1 && state_q.fault == '0));

    // R6
    pair_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.fault != '0 && !clr_hit) |=> (state_q.fault == $past(state_q.fault)));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (fault_flags == '0 && !mismatch));

    // R8
    status_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && cmd_addr == STAT_ADDR) |->
            (rd_data[STAT_W-1:NCH+1] == '0 && rd_data[NCH] == mismatch));
endmodule

// File: tb/sift_voter_test.sv
module sift_voter_test;
    localparam int W = 8;
    localparam int AW = 16;
    localparam logic [AW-1:0] STAT = 16'hFF40;
    localparam logic [AW-1:0] CLR  = 16'hFF41;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  da = '0, db = '0, dc = '0;
    logic [W-1:0]  bus_out;
    logic [2:0]    fault_flags;
    logic          mismatch;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_rd = 1'b0, cmd_wr = 1'b0;
    logic [7:0]    rd_data;

    int   n_chk = 0;
    int   n_err = 0;
    logic [2:0] mf = '0;
    logic       mu = 1'b0;

    always #2 clk = ~clk;

    sift_voter #(.W(W), .AW(AW), .STAT_ADDR(STAT), .CLR_ADDR(CLR)) uut (
        .clk(clk), .rst_n(rst_n), .data_a(da), .data_b(db), .data_c(dc),
        .bus_out(bus_out), .fault_flags(fault_flags), .mismatch(mismatch),
        .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .rd_data(rd_data)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // returns {unres, odd[2:0]}
    function automatic logic [3:0] m_cmp(input logic [2:0] f, input logic [W-1:0] a, b, c);
        if (f == 3'b000) begin
            if (a == b && a == c) return 4'b0000;
            if (a == b) return 4'b0100;
            if (a == c) return 4'b0010;
            if (b == c) return 4'b0001;
            return 4'b1000;
        end
        if (f == 3'b001) return {(b != c), 3'b000};
        if (f == 3'b010) return {(a != c), 3'b000};
        return {(a != b), 3'b000};
    endfunction

    function automatic logic [W-1:0] m_out(input logic [2:0] drop, input logic [W-1:0] a, b, c);
        logic [W-1:0] o = '0;
        if (!drop[0]) o |= a;
        if (!drop[1]) o |= b;
        if (!drop[2]) o |= c;
        return o;
    endfunction

    task automatic step(input logic [W-1:0] a, b, c, input logic [AW-1:0] ad,
                        input logic rd, input logic wr, input string req);
        logic [3:0] r;
        logic [7:0] er;
        @(negedge clk);
        da = a; db = b; dc = c; cmd_addr = ad; cmd_rd = rd; cmd_wr = wr;
        #1;
        r  = m_cmp(mf, a, b, c);
        er = (rd && ad == STAT) ? {4'b0, mu, mf} : 8'h00;
        chk(bus_out == m_out(mf | r[2:0], a, b, c), req, bus_out, m_out(mf | r[2:0], a, b, c));
        chk(fault_flags == mf, req, fault_flags, mf);
        chk(mismatch == mu, req, mismatch, mu);
        chk(rd_data == er, req, rd_data, er);
        if (wr && ad == CLR) begin
            mf = '0; mu = 1'b0;
        end else begin
            mf |= r[2:0]; mu |= r[3];
        end
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        cmd_addr = STAT; cmd_rd = 1'b1;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(fault_flags == 3'b000, "R1", fault_flags, 0);
        chk(mismatch == 1'b0, "R1", mismatch, 0);
        chk(rd_data == 8'h00, "R1", rd_data, 0);
        rst_n = 1'b1;
        step(8'h00, 8'h00, 8'h00, STAT, 1, 0, "R1");
        // R2 agreement
        step(8'h5A, 8'h5A, 8'h5A, 16'h0000, 0, 0, "R2");
        step(8'hFF, 8'hFF, 8'hFF, 16'h0000, 0, 0, "R2");
        // R3/R4 channel b breaks
        step(8'h11, 8'h13, 8'h11, 16'h0000, 0, 0, "R3");
        step(8'h22, 8'h22, 8'h22, STAT, 1, 0, "R4");
        chk(fault_flags == 3'b010, "R4", fault_flags, 3'b010);
        // R5 stuck b ignored
        step(8'h30, 8'hC3, 8'h30, 16'h0000, 0, 0, "R5");
        step(8'h01, 8'hFF, 8'h01, STAT, 1, 0, "R5");
        chk(bus_out == 8'h01, "R5", bus_out, 8'h01);
        // R6 remaining pair disagrees
        step(8'h40, 8'h00, 8'h04, 16'h0000, 0, 0, "R6");
        chk(bus_out == 8'h44, "R6", bus_out, 8'h44);
        step(8'h40, 8'h00, 8'h40, STAT, 1, 0, "R6");
        chk(mismatch == 1'b1 && fault_flags == 3'b010, "R6", {mismatch, fault_flags}, 4'b1010);
        // R8 status byte format
        step(8'h40, 8'h40, 8'h40, STAT, 1, 0, "R8");
        chk(rd_data == 8'h0A, "R8", rd_data, 8'h0A);
        step(8'h40, 8'h40, 8'h40, STAT, 0, 0, "R8");
        // R10 no-effect commands
        step(8'h40, 8'h40, 8'h40, 16'h1234, 0, 1, "R10");
        step(8'h40, 8'h40, 8'h40, CLR, 1, 0, "R10");
        step(8'h40, 8'h40, 8'h40, STAT, 1, 0, "R10");
        chk(fault_flags == 3'b010 && mismatch, "R10", {mismatch, fault_flags}, 4'b1010);
        // R9 clear
        step(8'h40, 8'h40, 8'h40, CLR, 0, 1, "R9");
        step(8'h07, 8'h07, 8'h07, STAT, 1, 0, "R9");
        chk(fault_flags == 3'b000 && !mismatch, "R9", {mismatch, fault_flags}, 0);
        // R9 clear wins over same-cycle detection on channel c
        step(8'h07, 8'h07, 8'h87, CLR, 0, 1, "R9");
        step(8'h07, 8'h07, 8'h07, STAT, 1, 0, "R9");
        chk(fault_flags == 3'b000, "R9", fault_flags, 0);
        // R4 channel a index
        step(8'h80, 8'h08, 8'h08, 16'h0000, 0, 0, "R3");
        step(8'h08, 8'h08, 8'h08, STAT, 1, 0, "R4");
        chk(fault_flags == 3'b001, "R4", fault_flags, 3'b001);
        step(8'h00, 8'h00, 8'h00, CLR, 0, 1, "R9");
        // R7 three-way disagreement
        step(8'h01, 8'h02, 8'h04, 16'h0000, 0, 0, "R7");
        chk(bus_out == 8'h07, "R7", bus_out, 8'h07);
        step(8'h00, 8'h00, 8'h00, STAT, 1, 0, "R7");
        chk(mismatch && fault_flags == 3'b000, "R7", {mismatch, fault_flags}, 4'b1000);
        step(8'h00, 8'h00, 8'h00, CLR, 0, 1, "R9");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] v, a, b, c, x;
            logic [AW-1:0] ad;
            int sel;
            v = W'($urandom);
            a = v; b = v; c = v;
            if ($urandom_range(7) == 0) begin
                x = W'($urandom_range(255, 1));
                sel = $urandom_range(2);
                if (sel == 0) a ^= x;
                else if (sel == 1) b ^= x;
                else c ^= x;
            end
            sel = $urandom_range(15);
            ad = (sel < 6) ? STAT : (sel == 6) ? CLR : AW'($urandom);
            step(a, b, c, ad, $urandom_range(3) == 0, $urandom_range(1) == 0, "R2");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule